// File: doc/BRIEF.md
# Write Leveling Responder (x16, two byte lanes)

This block is the memory-device side of write leveling for a sixteen-bit part made of two byte lanes. The controller places the device in leveling mode through a mode-register load. In that mode, every rising edge of a lane's data strobe samples the current level of the device clock. The sampled level is driven back on that lane's prime DQ bit. The controller sweeps its strobe delay until it sees the reported level change from 0 to 1.

The block holds the two mode-register bits it needs: leveling enable and output-buffer disable. It detects strobe rising edges on its own system clock and keeps one sampled bit per lane. It builds the 16-bit DQ value, a per-bit DQ output enable, and the termination enables for the strobes and the DQ pins. The termination enables are formed from the mode bits and the ODT input.

Top module: `wlvl_responder`

## Requirements
- R1: After reset, leveling is off, the output-buffer-disable bit is clear, `dq_oe` and `dq_out` are all zero, and both stored samples are 0.
- R2: While leveling is active (leveling enable 1, output disable 0), a clock edge is a rising edge on lane 0 when it sees `dqs_in[0]` high and the previous edge saw it low. On that edge the block captures `ck_level`, and bit 0 of `dq_out` shows the captured value from that edge onward.
- R3: Lane 1 behaves the same way on `dqs_in[1]`, with its prime bit at `dq_out[8]`. Each lane updates only on its own strobe.
- R4: A prime bit keeps its value until the next rising edge of its own strobe. Falling edges and a strobe held high leave it unchanged.
- R5: While leveling is active, `dq_oe` is all ones and every bit of `dq_out` other than bits 0 and 8 is 0.
- R6: With output disable set, `dq_oe` and `dq_out` are all zero and strobe edges do not change the stored samples. The stored values become visible again once output disable is cleared while leveling stays on.
- R7: `dqs_term_en` (one bit per lane) equals ODT in every mode. `dq_term_en` is 0 whenever leveling is enabled.
- R8: With leveling disabled, `dq_oe` and `dq_out` are zero, `dq_term_en` follows ODT, and strobe edges do not change the stored samples.
- R9: A load that turns leveling on while it was off clears both stored samples to 0, even when a strobe rises on the same edge.
- R10: The mode bits change only on an edge where `mr1_load` is 1. On other edges the values on `mr1_lvl_in` and `mr1_qoff_in` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| mr1_load | input | 1 | Loads the two mode bits on this edge |
| mr1_lvl_in | input | 1 | Leveling enable value to load |
| mr1_qoff_in | input | 1 | Output-buffer disable value to load |
| odt | input | 1 | On-die termination request |
| ck_level | input | 1 | Current level of the device clock |
| dqs_in | input | 2 | Data strobes, bit 0 lower lane, bit 1 upper lane |
| dq_out | output | 16 | DQ drive value |
| dq_oe | output | 16 | Per-bit DQ output enable |
| dqs_term_en | output | 2 | Per-lane strobe termination enable |
| dq_term_en | output | 1 | DQ termination enable |

## Verification
The assertions check several properties on every cycle:
- the output enable is always either all ones or all zeros;
- non-prime bits stay low;
- DQ termination is off whenever outputs are driven;
- a prime bit stays stable on edges without a strobe rise or mode load;
- a rise during active leveling captures the clock level;
- a load with output disable or with leveling off blanks the outputs;
- entering leveling clears both samples.

Only the bench scenarios can show the remaining behaviours. These are that samples survive an output-disable period and show again afterwards, that mode inputs without a load have no effect, that the two lanes stay independent under random strobe patterns, and that entry clearing wins over a simultaneous strobe rise.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;

  typedef struct packed {
    logic lvl_en;
    logic qoff;
  } mode_bits_t;

endpackage

// File: rtl/wlvl_mode_reg.sv
module wlvl_mode_reg
  import wlvl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       lvl_in,
  input  logic       qoff_in,
  output mode_bits_t mode_q,
  output logic       enter_o
);

  mode_bits_t mode_d;

  always_comb begin
    mode_d = mode_q;
    if (load) begin
      mode_d.lvl_en = lvl_in;
      mode_d.qoff   = qoff_in;
    end
  end

  assign enter_o = load & lvl_in & ~mode_q.lvl_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (load) begin
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/wlvl_lane_sampler.sv
module wlvl_lane_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic dqs,
  input  logic ck_level,
  input  logic arm,
  input  logic clear,
  output logic samp_o
);

  logic prev_q;
  logic samp_q;
  logic samp_d;
  logic rise;

  assign rise = dqs & ~prev_q;

  always_comb begin
    samp_d = samp_q;
    if (clear) begin
      samp_d = 1'b0;
    end else if (arm && rise) begin
      samp_d = ck_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      samp_q <= 1'b0;
    end else begin
      prev_q <= dqs;
      samp_q <= samp_d;
    end
  end

  assign samp_o = samp_q;

endmodule

// File: rtl/wlvl_out_ctrl.sv
module wlvl_out_ctrl
  import wlvl_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int LANE_W    = 8,
  parameter int PRIME_BIT = 0,
  localparam int DQ_W     = LANES * LANE_W
) (
  input  mode_bits_t       mode,
  input  logic [LANES-1:0] samp,
  input  logic             odt,
  output logic [DQ_W-1:0]  dq_out,
  output logic [DQ_W-1:0]  dq_oe,
  output logic [LANES-1:0] dqs_term_en,
  output logic             dq_term_en
);

  logic active;

  assign active = mode.lvl_en & ~mode.qoff;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    for (genvar b = 0; b < LANE_W; b++) begin : g_bit
      if (b == PRIME_BIT) begin : g_prime
        assign dq_out[ln*LANE_W+b] = active & samp[ln];
      end else begin : g_other
        assign dq_out[ln*LANE_W+b] = 1'b0;
      end
      assign dq_oe[ln*LANE_W+b] = active;
    end
    assign dqs_term_en[ln] = odt;
  end

  assign dq_term_en = odt & ~mode.lvl_en;

endmodule

// File: rtl/wlvl_responder.sv
module wlvl_responder
  import wlvl_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int LANE_W    = 8,
  parameter int PRIME_BIT = 0,
  localparam int DQ_W     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mr1_load,
  input  logic             mr1_lvl_in,
  input  logic             mr1_qoff_in,
  input  logic             odt,
  input  logic             ck_level,
  input  logic [LANES-1:0] dqs_in,
  output logic [DQ_W-1:0]  dq_out,
  output logic [DQ_W-1:0]  dq_oe,
  output logic [LANES-1:0] dqs_term_en,
  output logic             dq_term_en
);

  mode_bits_t       mode_q;
  logic             enter;
  logic             arm;
  logic [LANES-1:0] samp;

  wlvl_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (mr1_load),
    .lvl_in  (mr1_lvl_in),
    .qoff_in (mr1_qoff_in),
    .mode_q  (mode_q),
    .enter_o (enter)
  );

  assign arm = mode_q.lvl_en & ~mode_q.qoff;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_smp
    wlvl_lane_sampler u_smp (
      .clk      (clk),
      .rst_n    (rst_n),
      .dqs      (dqs_in[ln]),
      .ck_level (ck_level),
      .arm      (arm),
      .clear    (enter),
      .samp_o   (samp[ln])
    );
  end

  wlvl_out_ctrl #(
    .LANES     (LANES),
    .LANE_W    (LANE_W),
    .PRIME_BIT (PRIME_BIT)
  ) u_out (
    .mode        (mode_q),
    .samp        (samp),
    .odt         (odt),
    .dq_out      (dq_out),
    .dq_oe       (dq_oe),
    .dqs_term_en (dqs_term_en),
    .dq_term_en  (dq_term_en)
  );

endmodule

// File: rtl/wlvl_responder_chk.sv
module wlvl_responder_chk #(
  parameter int LANES     = 2,
  parameter int LANE_W    = 8,
  parameter int PRIME_BIT = 0,
  localparam int DQ_W     = LANES * LANE_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mr1_load,
  input logic             mr1_lvl_in,
  input logic             mr1_qoff_in,
  input logic             odt,
  input logic             ck_level,
  input logic [LANES-1:0] dqs_in,
  input logic [DQ_W-1:0]  dq_out,
  input logic [DQ_W-1:0]  dq_oe,
  input logic             dq_term_en,
  input logic             lvl_en_q
);

  function automatic logic [DQ_W-1:0] prime_mask();
    logic [DQ_W-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++) m[i*LANE_W+PRIME_BIT] = 1'b1;
    return m;
  endfunction

  p_oe_uniform_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == '0) || (dq_oe == '1));

  p_nonprime_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_out & ~prime_mask()) == '0);

  p_dq_term_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe != '0) |-> !dq_term_en);

  p_qoff_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mr1_load && mr1_qoff_in) |=> (dq_oe == '0 && dq_out == '0));

  p_normal_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mr1_load && !mr1_lvl_in) |=> (dq_oe == '0 && dq_out == '0));

  p_entry_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mr1_load && mr1_lvl_in && !lvl_en_q) |=> (dq_out == '0));

  for (genvar ln = 0; ln < LANES; ln++) begin : g_ln
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$rose(dqs_in[ln]) && !mr1_load)
        |=> $stable(dq_out[ln*LANE_W+PRIME_BIT]));

    p_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && dq_oe[0] && !mr1_load && $rose(dqs_in[ln]))
        |=> (dq_out[ln*LANE_W+PRIME_BIT] == $past(ck_level)));
  end

endmodule

bind wlvl_responder wlvl_responder_chk #(
  .LANES     (LANES),
  .LANE_W    (LANE_W),
  .PRIME_BIT (PRIME_BIT)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .mr1_load    (mr1_load),
  .mr1_lvl_in  (mr1_lvl_in),
  .mr1_qoff_in (mr1_qoff_in),
  .odt         (odt),
  .ck_level    (ck_level),
  .dqs_in      (dqs_in),
  .dq_out      (dq_out),
  .dq_oe       (dq_oe),
  .dq_term_en  (dq_term_en),
  .lvl_en_q    (mode_q.lvl_en)
);

// File: tb/wlvl_responder_tb.sv
module wlvl_responder_tb_top;

  logic        clk;
  logic        rst_n;
  logic        mr1_load, mr1_lvl_in, mr1_qoff_in, odt, ck_level;
  logic [1:0]  dqs_in;
  logic [15:0] dq_out, dq_oe;
  logic [1:0]  dqs_term_en;
  logic        dq_term_en;

  int n_checks = 0;
  int n_fail   = 0;

  logic       m_lvl, m_qoff;
  logic [1:0] m_samp, m_prev;

  wlvl_responder dut_i (
    .clk(clk), .rst_n(rst_n), .mr1_load(mr1_load), .mr1_lvl_in(mr1_lvl_in),
    .mr1_qoff_in(mr1_qoff_in), .odt(odt), .ck_level(ck_level), .dqs_in(dqs_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .dqs_term_en(dqs_term_en), .dq_term_en(dq_term_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic exp_active();
    return m_lvl & ~m_qoff;
  endfunction

  function automatic logic [15:0] exp_out();
    logic [15:0] v;
    v = '0;
    if (exp_active()) begin
      v[0] = m_samp[0];
      v[8] = m_samp[1];
    end
    return v;
  endfunction

  function automatic logic [15:0] exp_oe();
    return exp_active() ? 16'hFFFF : 16'h0000;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    string t;
    t = !m_lvl ? "R8" : (m_qoff ? "R6" : "R5");
    chk(dq_oe == exp_oe(), {t, " dq_oe"}, 32'(dq_oe), 32'(exp_oe()));
    chk(dq_out[0] == exp_out()[0], "R2 lane0 prime", 32'(dq_out[0]), 32'(exp_out()[0]));
    chk(dq_out[8] == exp_out()[8], "R3 lane1 prime", 32'(dq_out[8]), 32'(exp_out()[8]));
    chk((dq_out & 16'hFEFE) == 16'h0, "R5 nonprime", 32'(dq_out), 32'(exp_out()));
    chk(dqs_term_en == {2{odt}}, "R7 dqs term", 32'(dqs_term_en), 32'({2{odt}}));
    chk(dq_term_en == (odt & ~m_lvl), m_lvl ? "R7 dq term" : "R8 dq term",
        32'(dq_term_en), 32'(odt & ~m_lvl));
  endtask

  // Drive inputs after negedge, advance model at posedge, check at next negedge.
  task automatic step(input logic ld, input logic lv, input logic qo, input logic o,
                      input logic ck, input logic [1:0] ds);
    logic enter, arm;
    mr1_load = ld; mr1_lvl_in = lv; mr1_qoff_in = qo;
    odt = o; ck_level = ck; dqs_in = ds;
    @(posedge clk);
    enter = ld & lv & ~m_lvl;
    arm   = m_lvl & ~m_qoff;
    for (int i = 0; i < 2; i++) begin
      if (enter) m_samp[i] = 1'b0;
      else if (arm && ds[i] && !m_prev[i]) m_samp[i] = ck;
    end
    m_prev = ds;
    if (ld) begin m_lvl = lv; m_qoff = qo; end
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5EED_0017;
    void'($urandom(seed));
    rst_n = 1'b0;
    mr1_load = 0; mr1_lvl_in = 0; mr1_qoff_in = 0; odt = 0; ck_level = 0; dqs_in = 0;
    m_lvl = 0; m_qoff = 0; m_samp = 0; m_prev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(dq_oe == 16'h0, "R1 oe after reset", 32'(dq_oe), 0);
    chk(dq_out == 16'h0, "R1 out after reset", 32'(dq_out), 0);
    chk(dq_term_en == 1'b0, "R1 dq term with odt low", 32'(dq_term_en), 0);

    // R8: strobes ignored in normal mode
    step(0,0,0,1,1,2'b00); step(0,0,0,1,1,2'b11);
    // enter leveling, R9
    step(1,1,0,0,1,2'b00);
    chk(dq_out == 16'h0, "R9 cleared on entry", 32'(dq_out), 0);
    // R2 lane 0 samples 1, lane 1 idle
    step(0,0,0,0,1,2'b01);
    chk(dq_out == 16'h0001, "R2 lane0 sample", 32'(dq_out), 32'h1);
    // R4 hold while high and on falling edge with ck changed
    step(0,0,0,0,0,2'b01); step(0,0,0,0,0,2'b00);
    chk(dq_out == 16'h0001, "R4 hold", 32'(dq_out), 32'h1);
    // R3 lane 1 independent
    step(0,0,0,1,1,2'b10);
    chk(dq_out == 16'h0101, "R3 lane1 sample", 32'(dq_out), 32'h101);
    // R10: mode inputs without load are ignored
    step(0,0,1,0,0,2'b00); step(0,0,1,0,0,2'b00);
    chk(dq_oe == 16'hFFFF, "R10 no load no change", 32'(dq_oe), 32'hFFFF);
    // R6: output disable, edges ignored, values return
    step(1,1,1,1,0,2'b00); step(0,0,0,1,0,2'b11); step(0,0,0,1,0,2'b00);
    chk(dq_oe == 16'h0, "R6 oe off", 32'(dq_oe), 0);
    step(1,1,0,0,0,2'b00);
    chk(dq_out == 16'h0101, "R6 samples kept", 32'(dq_out), 32'h101);
    // R9: exit then re-enter with simultaneous rise, clear wins
    step(1,0,0,0,1,2'b00);
    step(1,1,0,0,1,2'b11);
    chk(dq_out == 16'h0, "R9 clear beats rise", 32'(dq_out), 0);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic ld;
      ld = ($urandom % 16) == 0;
      step(ld, ($urandom % 4) != 0, ($urandom % 4) == 0, 1'($urandom),
           1'($urandom), 2'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule